// File: doc/BRIEF.md
# Event Interrupt Status Controller

This block gathers a set of event input lines into per-bank maskable interrupts. The events are split into banks. Bank 0 holds 19 events, and each later bank holds 32. A rising edge on an event line marks that event pending in the bank's raw status vector. Software masks pending events with an enable vector, and the interrupt line of a bank is high while any enabled event in it is pending. Software can also inject events for debug by writing the raw status. It retires events by writing ones to the enabled-status view.

A second function is a vector of software-controlled output event lines. One register address raises selected lines and another lowers them. Both addresses read back the present levels.

The register port is a plain single-cycle strobe interface with no back-pressure. A write takes effect at the clock edge on which `bus_wen` is sampled high. Reads are combinational from `bus_addr`. Access is by 32-bit word, and only word-aligned addresses are decoded.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset every raw status bit, enable bit and output event line is 0, every `irq` bit is 0, and every decoded register reads 0.
- R2: A 0-to-1 transition of `evt_in[i]` sets the raw bit for that event at the clock edge where the high level is first sampled. A level held high sets it only once, so after a clear it stays 0 until the line falls and rises again. Event i maps to bank 0 bit i for i < 19, and otherwise to bank 1 + (i-19)/32, bit (i-19)%32.
- R3: Bank b's raw status register is at byte address b*0x10. Writing 1 to a bit there sets the pending bit, writing 0 leaves it unchanged, and a read returns the raw vector.
- R4: The enabled-status register at b*0x10+0x4 reads raw AND enable. Writing 1 to a bit there clears that raw bit whatever the enable is, and writing 0 has no effect.
- R5: Writing 1 to a bit at b*0x10+0x8 sets that enable bit, and writing 1 at b*0x10+0xC clears it. Writing 0 to either address has no effect, and both addresses read the enable vector.
- R6: Bank 0 implements only bits 18:0. Its bits 31:19 read 0 in every one of its registers, and writes to them are ignored.
- R7: When an event edge and a software clear of the same raw bit occur in the same cycle, the bit ends up set.
- R8: `irq[b]` is a register that equals the OR of bank b's enabled-status bits as they were one cycle earlier. It rises or falls one clock after the status changes.
- R9: Writing 1 to a bit at byte address 0x80 drives that `evt_out` line high, and writing 1 at 0x84 drives it low. Writing 0 has no effect, and both addresses read the current `evt_out` levels.
- R10: Addresses outside the map, and any address with bits 1:0 non-zero, read 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_in | input | 83 | Event input lines, all banks concatenated, bank 0 at the low end |
| irq | output | 3 | One registered interrupt per bank |
| evt_out | output | 32 | Software-controlled output event lines |

## Verification
A wrong raw or enable bit shows up on a read of the raw or enable address as soon as the access is made. It also reaches `irq` exactly one clock later, so every check on the interrupt samples both the cycle just after the status change and the cycle after that. A lost or repeated edge detection appears as a missing pending bit, or as a bit that comes back after a clear while its line is still held high. The bench therefore sweeps every event line through both a pulse and a held level. A bad address decode moves a write into the wrong bank or register, and reading back all four addresses of every bank exposes it.

// File: rtl/eic_pkg.sv
package eic_pkg;

  // Register kind selected by word-address bits [1:0] inside a bank window
  typedef enum logic [1:0] {
    RK_RAW   = 2'd0,
    RK_STAT  = 2'd1,
    RK_ENSET = 2'd2,
    RK_ENCLR = 2'd3
  } reg_kind_e;

  localparam int REGS_PER_BANK = 4;

  function automatic int bank_width(input int b, input int first_w, input int full_w);
    return (b == 0) ? first_w : full_w;
  endfunction

  function automatic int bank_lsb(input int b, input int first_w, input int full_w);
    return (b == 0) ? 0 : first_w + full_w * (b - 1);
  endfunction

endpackage

// File: rtl/eic_bank.sv
module eic_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] raw_set_i,
  input  logic [W-1:0] raw_clr_i,
  input  logic [W-1:0] en_set_i,
  input  logic [W-1:0] en_clr_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);

  logic [W-1:0] evt_q;
  logic [W-1:0] raw_q;
  logic [W-1:0] en_q;
  logic         irq_q;
  logic [W-1:0] edge_v;

  assign edge_v = evt_i & ~evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      raw_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= evt_i;
      // set sources (edge, debug inject) override a software clear
      raw_q <= (raw_q & ~raw_clr_i) | raw_set_i | edge_v;
      en_q  <= (en_q | en_set_i) & ~en_clr_i;
      irq_q <= |(raw_q & en_q);
    end
  end

  assign raw_o  = raw_q;
  assign en_o   = en_q;
  assign stat_o = raw_q & en_q;
  assign irq_o  = irq_q;

  // R2
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_v) |=> ((raw_q & $past(edge_v)) == $past(edge_v)));

  // R7
  hw_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_v & raw_clr_i)) |=> ((raw_q & $past(edge_v & raw_clr_i)) == $past(edge_v & raw_clr_i)));

  // R4
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_clr_i & ~edge_v & ~raw_set_i)) |=> ((raw_q & $past(raw_clr_i & ~edge_v & ~raw_set_i)) == '0));

  // R5
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr_i) |=> ((en_q & $past(en_clr_i)) == '0));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(raw_q) && $stable(en_q)) |-> (irq_q == |(raw_q & en_q)));

endmodule

// File: rtl/eic_outpair.sv
module eic_outpair #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] lvl_o
);

  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= (lvl_q & ~clr_i) | set_i;
  end

  assign lvl_o = lvl_q;

  // R9
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((lvl_q & $past(set_i)) == $past(set_i)));

  // R9
  out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((lvl_q & $past(clr_i & ~set_i)) == '0));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(lvl_q));

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import eic_pkg::*;
#(
  parameter int FIRST_W    = 19,
  parameter int FULL_BANKS = 2,
  parameter int DATA_W     = 32,
  parameter int OUT_W      = 32,
  parameter int ADDR_W     = 8,
  localparam int NBANK     = FULL_BANKS + 1,
  localparam int NEVT      = FIRST_W + DATA_W * FULL_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NEVT-1:0]   evt_in,
  output logic [NBANK-1:0]  irq,
  output logic [OUT_W-1:0]  evt_out
);

  localparam int WORD_W        = ADDR_W - 2;
  localparam int BSEL_W        = WORD_W - 2;
  localparam int OUT_SET_WORD  = 2 ** (WORD_W - 1);
  localparam int OUT_CLR_WORD  = OUT_SET_WORD + 1;
  localparam int BANK_WORDS    = NBANK * REGS_PER_BANK;

  logic              aligned;
  logic [WORD_W-1:0] word;
  logic              wr_ok;
  reg_kind_e         kind;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign word    = bus_addr[ADDR_W-1:2];
  assign wr_ok   = bus_wen && aligned;
  assign kind    = reg_kind_e'(word[1:0]);

  logic [DATA_W-1:0] raw_pad  [NBANK];
  logic [DATA_W-1:0] en_pad   [NBANK];
  logic [DATA_W-1:0] stat_pad [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int W   = bank_width(b, FIRST_W, DATA_W);
    localparam int LSB = bank_lsb(b, FIRST_W, DATA_W);

    logic [W-1:0] s_raw_set, s_raw_clr, s_en_set, s_en_clr;
    logic [W-1:0] b_raw, b_en, b_stat;

    assign s_raw_set = (wr_ok && word == WORD_W'(REGS_PER_BANK*b + 0)) ? bus_wdata[W-1:0] : '0;
    assign s_raw_clr = (wr_ok && word == WORD_W'(REGS_PER_BANK*b + 1)) ? bus_wdata[W-1:0] : '0;
    assign s_en_set  = (wr_ok && word == WORD_W'(REGS_PER_BANK*b + 2)) ? bus_wdata[W-1:0] : '0;
    assign s_en_clr  = (wr_ok && word == WORD_W'(REGS_PER_BANK*b + 3)) ? bus_wdata[W-1:0] : '0;

    eic_bank #(.W(W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_in[LSB +: W]),
      .raw_set_i (s_raw_set),
      .raw_clr_i (s_raw_clr),
      .en_set_i  (s_en_set),
      .en_clr_i  (s_en_clr),
      .raw_o     (b_raw),
      .en_o      (b_en),
      .stat_o    (b_stat),
      .irq_o     (irq[b])
    );

    assign raw_pad[b]  = DATA_W'(b_raw);
    assign en_pad[b]   = DATA_W'(b_en);
    assign stat_pad[b] = DATA_W'(b_stat);
  end

  logic [OUT_W-1:0] o_set, o_clr;
  assign o_set = (wr_ok && word == WORD_W'(OUT_SET_WORD)) ? bus_wdata[OUT_W-1:0] : '0;
  assign o_clr = (wr_ok && word == WORD_W'(OUT_CLR_WORD)) ? bus_wdata[OUT_W-1:0] : '0;

  eic_outpair #(.W(OUT_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (o_set),
    .clr_i (o_clr),
    .lvl_o (evt_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (word < WORD_W'(BANK_WORDS)) begin
        for (int b = 0; b < NBANK; b++) begin
          if (word[WORD_W-1:2] == BSEL_W'(b)) begin
            unique case (kind)
              RK_RAW:             bus_rdata = raw_pad[b];
              RK_STAT:            bus_rdata = stat_pad[b];
              RK_ENSET, RK_ENCLR: bus_rdata = en_pad[b];
              default:            bus_rdata = '0;
            endcase
          end
        end
      end else if (word == WORD_W'(OUT_SET_WORD) || word == WORD_W'(OUT_CLR_WORD)) begin
        bus_rdata = DATA_W'(evt_out);
      end
    end
  end

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!aligned) |-> (bus_rdata == '0));

  // R8
  irq_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0));

endmodule

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;

  localparam int NEVT = 83;
  localparam int NB   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NEVT-1:0] evt_in = '0;
  logic [NB-1:0]   irq;
  logic [31:0]     evt_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  evt_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .irq(irq), .evt_out(evt_out)
  );

  function automatic logic [31:0] bmask(input int b);
    return (b == 0) ? 32'h0007_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [7:0] ra(input int b, input int k);
    return 8'(b * 16 + k * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(posedge clk); #1;
    bus_wen = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic clear_bank(input int b);
    wr(ra(b, 1), 32'hFFFF_FFFF);
    wr(ra(b, 3), 32'hFFFF_FFFF);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] p, q, e, r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;

    // R1 reset state
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < 4; k++) rd_chk("R1 reg", ra(b, k), 32'h0);
    rd_chk("R1 out", 8'h80, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 evt_out", evt_out, 32'h0);

    // R10 unmapped and misaligned
    rd_chk("R10 unmapped", 8'h40, 32'h0);
    rd_chk("R10 unmapped hi", 8'hFC, 32'h0);
    wr(8'h81, 32'hFFFF_FFFF);
    rd_chk("R10 misaligned write", 8'h80, 32'h0);
    rd_chk("R10 misaligned read", 8'h81, 32'h0);
    wr(8'h01, 32'hFFFF_FFFF);
    rd_chk("R10 misaligned raw", ra(0, 0), 32'h0);

    // R5 / R6 enable set and clear per bank
    for (int b = 0; b < NB; b++) begin
      p = 32'hA5C3_0F69 ^ (32'h1111_1111 * b);
      q = 32'h00FF_FF00;
      wr(ra(b, 2), p);
      rd_chk("R5 enset read", ra(b, 2), p & bmask(b));
      rd_chk("R5 enclr read", ra(b, 3), p & bmask(b));
      wr(ra(b, 2), 32'h0);
      rd_chk("R5 enset zero", ra(b, 2), p & bmask(b));
      wr(ra(b, 3), q);
      rd_chk("R5 enclr", ra(b, 2), p & ~q & bmask(b));
      wr(ra(b, 3), 32'h0);
      rd_chk("R5 enclr zero", ra(b, 3), p & ~q & bmask(b));
      clear_bank(b);
    end
    wr(ra(0, 2), 32'hFFFF_FFFF);
    rd_chk("R6 bank0 enable width", ra(0, 2), 32'h0007_FFFF);
    wr(ra(0, 0), 32'hFFFF_FFFF);
    rd_chk("R6 bank0 raw width", ra(0, 0), 32'h0007_FFFF);
    rd_chk("R6 bank0 stat width", ra(0, 1), 32'h0007_FFFF);
    clear_bank(0);
    repeat (2) @(posedge clk); #1;

    // R3 / R4 raw inject, enabled status, clear via status
    for (int b = 0; b < NB; b++) begin
      r = 32'h9C3A_5E17 + 32'h0101_0101 * b;
      e = 32'hF0F0_3C3C >> b;
      wr(ra(b, 0), r);
      rd_chk("R3 raw set", ra(b, 0), r & bmask(b));
      wr(ra(b, 0), 32'h0);
      rd_chk("R3 raw zero", ra(b, 0), r & bmask(b));
      wr(ra(b, 2), e);
      rd_chk("R4 stat read", ra(b, 1), r & e & bmask(b));
      q = 32'h0F0F_F00F;
      wr(ra(b, 1), q);
      rd_chk("R4 stat clear", ra(b, 0), r & ~q & bmask(b));
      wr(ra(b, 1), 32'h0);
      rd_chk("R4 stat zero", ra(b, 0), r & ~q & bmask(b));
      clear_bank(b);
    end
    repeat (2) @(posedge clk); #1;
    chk("R8 irq idle", 32'(irq), 32'h0);

    // R8 registered interrupt timing
    for (int b = 0; b < NB; b++) begin
      wr(ra(b, 2), 32'h0000_0020);
      chk("R8 irq before", 32'(irq[b]), 32'h0);
      wr(ra(b, 0), 32'h0000_0020);
      chk("R8 irq lag", 32'(irq[b]), 32'h0);
      @(posedge clk); #1;
      chk("R8 irq rise", 32'(irq), 32'(1 << b));
      wr(ra(b, 1), 32'h0000_0020);
      chk("R8 irq hold", 32'(irq[b]), 32'h1);
      @(posedge clk); #1;
      chk("R8 irq fall", 32'(irq), 32'h0);
      wr(ra(b, 0), 32'h0000_0040);
      repeat (2) @(posedge clk); #1;
      chk("R8 masked", 32'(irq), 32'h0);
      clear_bank(b);
    end

    // R2 edge detection, every event line
    for (int i = 0; i < NEVT; i++) begin
      int b, j;
      b = (i < 19) ? 0 : 1 + (i - 19) / 32;
      j = (i < 19) ? i : (i - 19) % 32;
      @(negedge clk); evt_in[i] = 1'b1;
      @(negedge clk); evt_in[i] = 1'b0;
      rd_chk("R2 edge", ra(b, 0), 32'(1) << j);
      wr(ra(b, 1), 32'(1) << j);
      rd_chk("R2 cleared", ra(b, 0), 32'h0);
    end

    // R2 held level sets only once
    @(negedge clk); evt_in[20] = 1'b1;
    repeat (2) @(posedge clk); #1;
    rd_chk("R2 held set", ra(1, 0), 32'h0000_0002);
    wr(ra(1, 1), 32'h0000_0002);
    repeat (3) @(posedge clk); #1;
    rd_chk("R2 held no reassert", ra(1, 0), 32'h0);
    @(negedge clk); evt_in[20] = 1'b0;
    @(negedge clk); evt_in[20] = 1'b1;
    @(negedge clk); evt_in[20] = 1'b0;
    rd_chk("R2 second edge", ra(1, 0), 32'h0000_0002);
    clear_bank(1);

    // R7 event edge and software clear in the same cycle
    wr(ra(1, 0), 32'h0020_0000);
    @(negedge clk);
    evt_in[40] = 1'b1;
    bus_addr = ra(1, 1); bus_wdata = 32'h0020_0000; bus_wen = 1'b1;
    @(posedge clk); #1;
    bus_wen = 1'b0;
    rd_chk("R7 hw wins", ra(1, 0), 32'h0020_0000);
    @(negedge clk); evt_in[40] = 1'b0;
    clear_bank(1);

    // R9 output event pair
    p = 32'h3C96_A50F;
    q = 32'h0FF0_F00F;
    wr(8'h80, p);
    chk("R9 set lines", evt_out, p);
    rd_chk("R9 set read", 8'h80, p);
    rd_chk("R9 clr read", 8'h84, p);
    wr(8'h84, q);
    chk("R9 clear lines", evt_out, p & ~q);
    wr(8'h80, 32'h0);
    chk("R9 set zero", evt_out, p & ~q);
    wr(8'h84, 32'h0);
    chk("R9 clear zero", evt_out, p & ~q);
    wr(8'h84, 32'hFFFF_FFFF);
    rd_chk("R9 all low", 8'h84, 32'h0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule